// File: doc/BRIEF.md
# Indirect Read Transfer Engine

This block copies a programmed number of bytes, beginning at a programmed flash address, from a byte-stream flash source into an on-chip byte buffer. Software loads the flash address, the byte count, a trigger base, a trigger range and an optional watermark. It then writes the start bit in the control register. The engine issues a single request pulse carrying the address and the length. It accepts bytes from the source while the buffer has room, and stalls the source while the buffer is full.

The host empties the buffer by reading any address inside the trigger window. Each such read returns the oldest buffered byte and removes it. Software can poll the fill-level register, or it can wait for the watermark interrupt, which signals that enough data is waiting. The transfer is complete when every programmed byte has been fetched from flash and read out by the host. At that point a done bit is set and a completion interrupt is raised. All interrupt causes are sticky, are cleared by writing 1, and are combined into one output through per-cause enables.

Top module: `ind_read_engine`

## Requirements
- R1: After reset all configuration registers, the fill level, the control word and the interrupt status read 0, and `irq` and `fl_ready` are low.
- R2: The register window is 64 bytes at parameter `REG_BASE`, selected by address bits [5:2]. The offsets are: 0x00 control, 0x04 flash address, 0x08 byte count, 0x0C trigger base, 0x10 trigger range, 0x14 watermark, 0x18 fill level (read only), 0x1C interrupt status, 0x20 interrupt enable. Each writable register reads back the value written to it; the count register holds CW bits and the enable register holds 3 bits.
- R3: A write of 1 to control bit 0 while idle starts a transfer. In that same cycle `fl_req` pulses with `fl_addr` equal to the flash address register and `fl_len` equal to the count register. A start written while a transfer is busy is ignored and gives no `fl_req`. Control bit 1 reads 1 while a transfer is busy.
- R4: A flash byte is accepted (`fl_ready` high) only while a transfer is busy, bytes remain to be fetched, and the buffer holds fewer than DEPTH bytes. The fill-level register reports the number of buffered bytes.
- R5: A host read whose address A satisfies base <= A < base+range returns the oldest buffered byte in bits [7:0], with zeros above, and removes that byte. Bytes come out in arrival order, and address base+range-1 is inside the window.
- R6: A host read outside the trigger window leaves the buffer unchanged. It returns register contents inside the register window, and 0 elsewhere (address base+range included).
- R7: A window read when the buffer is empty returns 0 and sets interrupt-status bit 2 (underflow).
- R8: With a nonzero watermark, interrupt-status bit 0 is set one cycle after the fill level first rises above the watermark.
- R9: With a nonzero watermark, status bit 0 is also set on the edge where the final byte of the transfer enters the buffer, even if the fill level never exceeds the watermark.
- R10: A watermark of 0 never sets status bit 0.
- R11: When all programmed bytes have been fetched and removed, control bit 5 reads 1, control bit 1 reads 0, and status bit 1 is set. Control bit 5 is cleared by the next accepted start.
- R12: Writing 1 to a status bit clears it, and a cause arising in the same cycle wins. `irq` is the OR of the status bits masked by the enable bits (bit 0 watermark, bit 1 done, bit 2 underflow).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | BW | Host byte address |
| host_wdata | input | BW | Host write data |
| host_rdata | output | BW | Host read data, valid in the strobe cycle |
| fl_req | output | 1 | One-cycle request pulse to the flash source |
| fl_addr | output | BW | Flash start address of the request |
| fl_len | output | CW | Byte count of the request |
| fl_valid | input | 1 | Flash byte valid |
| fl_data | input | 8 | Flash byte |
| fl_ready | output | 1 | Engine accepts the flash byte |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench builds the engine with DEPTH = 8 while transferring 10 bytes, so the buffer fills and the source visibly stalls before the host starts draining. A watermark of 3 on a 6-byte transfer exercises the rising-above cause. A watermark of 5 on a 3-byte transfer can only be met through the final-byte cause. The trigger window is 16 bytes at a base separate from the register window, which makes both window edges and ordinary unmapped addresses reachable.

// File: rtl/irde_pkg.sv
// Shared constants for the indirect read transfer engine: register
// selectors (address bits [5:2]) and bit positions inside control and
// interrupt words.
package irde_pkg;
    localparam logic [3:0] SEL_CTRL   = 4'd0;
    localparam logic [3:0] SEL_FADDR  = 4'd1;
    localparam logic [3:0] SEL_COUNT  = 4'd2;
    localparam logic [3:0] SEL_TBASE  = 4'd3;
    localparam logic [3:0] SEL_TRANGE = 4'd4;
    localparam logic [3:0] SEL_WMARK  = 4'd5;
    localparam logic [3:0] SEL_FILL   = 4'd6;
    localparam logic [3:0] SEL_ISTAT  = 4'd7;
    localparam logic [3:0] SEL_IEN    = 4'd8;

    localparam int CTRL_START = 0;
    localparam int CTRL_BUSY  = 1;
    localparam int CTRL_DONE  = 5;

    localparam int IRQ_WM    = 0;
    localparam int IRQ_DONE  = 1;
    localparam int IRQ_UFLOW = 2;
    localparam int IRQ_N     = 3;
endpackage

// File: rtl/irde_fifo.sv
// Byte buffer between the flash source and the host drain.
// Assumes DEPTH is a power of two and at least 2; pushes when full and
// pops when empty are dropped here, the callers are expected to gate them.
module irde_fifo #(
    parameter int DEPTH = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic [7:0]                     wdata,
    input  logic                           pop,
    output logic [7:0]                     head,
    output logic [$clog2(DEPTH+1)-1:0]     fill,
    output logic                           full,
    output logic                           empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int FW = $clog2(DEPTH + 1);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wp;
    logic [PW-1:0] rp;
    logic          do_push;
    logic          do_pop;

    assign full    = (fill == FW'(DEPTH));
    assign empty   = (fill == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    // Store incoming bytes at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    // Advance pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp   <= '0;
            rp   <= '0;
            fill <= '0;
        end else begin
            if (do_push) wp <= wp + PW'(1);
            if (do_pop)  rp <= rp + PW'(1);
            if (do_push && !do_pop)      fill <= fill + FW'(1);
            else if (do_pop && !do_push) fill <= fill - FW'(1);
        end
    end

    // R4: the fetch side never offers a byte into a full buffer
    a_r4_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);

    // R4: a lone accepted push grows the fill level by exactly one
    a_r4_fill_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !full) |=> (fill == $past(fill) + FW'(1)));
endmodule

// File: rtl/irde_fetch.sv
// Transfer sequencer: loads the byte count on start, hands flash bytes
// to the buffer while bytes remain and space exists, counts host pops,
// and reports completion once both counts reach zero.
// Assumes pop_ok is only asserted when the buffer actually held a byte.
module irde_fetch #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_req,
    input  logic [CW-1:0] count,
    input  logic          fl_valid,
    input  logic          buf_full,
    input  logic          pop_ok,
    output logic          start_go,
    output logic          active,
    output logic          fl_ready,
    output logic          push,
    output logic          last_push,
    output logic          done_pulse
);
    logic [CW-1:0] fetch_rem;
    logic [CW-1:0] pop_rem;

    assign start_go   = start_req && !active;
    assign fl_ready   = active && (fetch_rem != '0) && !buf_full;
    assign push       = fl_valid && fl_ready;
    assign last_push  = push && (fetch_rem == CW'(1));
    assign done_pulse = active && (fetch_rem == '0) && (pop_rem == '0);

    // Sequence state: busy flag and the two remaining-byte counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            fetch_rem <= '0;
            pop_rem   <= '0;
        end else if (start_go) begin
            active    <= 1'b1;
            fetch_rem <= count;
            pop_rem   <= count;
        end else begin
            if (done_pulse)                  active    <= 1'b0;
            if (push)                        fetch_rem <= fetch_rem - CW'(1);
            if (pop_ok && pop_rem != '0)     pop_rem   <= pop_rem - CW'(1);
        end
    end

    // R3: an accepted start makes the engine busy on the next cycle
    a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start_go |=> active);

    // R11: the host never removes more bytes than were programmed
    a_r11_pop_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        pop_ok |-> (pop_rem != '0));
endmodule

// File: rtl/irde_regs.sv
// Host-facing register file, trigger-window decode and interrupt logic.
// The trigger window takes priority over the register window when the two
// overlap. Assumes the flash byte count fits in CW bits of write data.
module irde_regs
    import irde_pkg::*;
#(
    parameter int             BW       = 32,
    parameter int             CW       = 16,
    parameter int             FW       = 5,
    parameter logic [BW-1:0]  REG_BASE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [BW-1:0] host_addr,
    input  logic [BW-1:0] host_wdata,
    output logic [BW-1:0] host_rdata,
    input  logic [FW-1:0] fill,
    input  logic          buf_empty,
    input  logic [7:0]    buf_head,
    input  logic          active,
    input  logic          start_go,
    input  logic          last_push,
    input  logic          done_pulse,
    output logic          start_req,
    output logic          win_pop,
    output logic [BW-1:0] flash_addr,
    output logic [CW-1:0] xfer_len,
    output logic          irq
);
    logic [BW-1:0]    tbase;
    logic [BW-1:0]    trange;
    logic [BW-1:0]    wmark;
    logic [IRQ_N-1:0] istat;
    logic [IRQ_N-1:0] ien;
    logic             done_bit;
    logic             above_q;

    logic [BW-1:0]    win_off;
    logic             in_win;
    logic             reg_hit;
    logic [3:0]       sel;
    logic             wr_reg;
    logic             uflow;
    logic [BW-1:0]    fill_ext;
    logic             wm_above;
    logic             wm_set;
    logic [IRQ_N-1:0] set_v;
    logic [IRQ_N-1:0] clr_v;
    logic [BW-1:0]    ctrl_word;

    // Address decode: trigger window first, then the register window.
    assign win_off   = host_addr - tbase;
    assign in_win    = (host_addr >= tbase) && (win_off < trange);
    assign reg_hit   = !in_win && (host_addr[BW-1:6] == REG_BASE[BW-1:6]);
    assign sel       = host_addr[5:2];
    assign wr_reg    = host_wr && reg_hit;
    assign start_req = wr_reg && (sel == SEL_CTRL) && host_wdata[CTRL_START];
    assign win_pop   = host_rd && in_win;
    assign uflow     = win_pop && buf_empty;

    // Watermark causes: first rise above the level, or the final byte.
    assign fill_ext  = {{(BW-FW){1'b0}}, fill};
    assign wm_above  = (wmark != '0) && (fill_ext > wmark);
    assign wm_set    = (wmark != '0) && ((wm_above && !above_q) || last_push);

    assign set_v = {uflow, done_pulse, wm_set};
    assign clr_v = (wr_reg && sel == SEL_ISTAT) ? host_wdata[IRQ_N-1:0] : '0;
    assign irq   = |(istat & ien);

    // Configuration registers written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flash_addr <= '0;
            xfer_len   <= '0;
            tbase      <= '0;
            trange     <= '0;
            wmark      <= '0;
            ien        <= '0;
        end else if (wr_reg) begin
            case (sel)
                SEL_FADDR:  flash_addr <= host_wdata;
                SEL_COUNT:  xfer_len   <= host_wdata[CW-1:0];
                SEL_TBASE:  tbase      <= host_wdata;
                SEL_TRANGE: trange     <= host_wdata;
                SEL_WMARK:  wmark      <= host_wdata;
                SEL_IEN:    ien        <= host_wdata[IRQ_N-1:0];
                default:    ;
            endcase
        end
    end

    // Sticky status, done flag and watermark edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            istat    <= '0;
            done_bit <= 1'b0;
            above_q  <= 1'b0;
        end else begin
            istat   <= (istat & ~clr_v) | set_v;
            above_q <= wm_above;
            if (start_go)        done_bit <= 1'b0;
            else if (done_pulse) done_bit <= 1'b1;
        end
    end

    // Control word as seen by the host.
    always_comb begin
        ctrl_word            = '0;
        ctrl_word[CTRL_BUSY] = active;
        ctrl_word[CTRL_DONE] = done_bit;
    end

    // Read data: buffer head inside the window, registers in their window.
    always_comb begin
        host_rdata = '0;
        if (in_win) begin
            if (!buf_empty) host_rdata = {{(BW-8){1'b0}}, buf_head};
        end else if (reg_hit) begin
            case (sel)
                SEL_CTRL:   host_rdata = ctrl_word;
                SEL_FADDR:  host_rdata = flash_addr;
                SEL_COUNT:  host_rdata = {{(BW-CW){1'b0}}, xfer_len};
                SEL_TBASE:  host_rdata = tbase;
                SEL_TRANGE: host_rdata = trange;
                SEL_WMARK:  host_rdata = wmark;
                SEL_FILL:   host_rdata = fill_ext;
                SEL_ISTAT:  host_rdata = {{(BW-IRQ_N){1'b0}}, istat};
                SEL_IEN:    host_rdata = {{(BW-IRQ_N){1'b0}}, ien};
                default:    host_rdata = '0;
            endcase
        end
    end

    // R7: a window read of an empty buffer leaves the underflow flag set
    a_r7_underflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (win_pop && buf_empty) |=> istat[IRQ_UFLOW]);

    // R10: with watermark zero the watermark flag cannot become set
    a_r10_wm_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wmark == '0 && !istat[IRQ_WM]) |=> !istat[IRQ_WM]);

    // R12: clearing the done flag works when no new completion coincides
    a_r12_w1c_done: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_reg && sel == SEL_ISTAT && host_wdata[IRQ_DONE] && !done_pulse)
            |=> !istat[IRQ_DONE]);

    // R11: completion is reflected in the control word next cycle
    a_r11_done_visible: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> done_bit);
endmodule

// File: rtl/ind_read_engine.sv
// Indirect read transfer engine top: ties the register file, the transfer
// sequencer and the byte buffer together. The flash request is the
// accepted start pulse with the programmed address and length.
module ind_read_engine #(
    parameter int             BW       = 32,
    parameter int             CW       = 16,
    parameter int             DEPTH    = 16,
    parameter logic [BW-1:0]  REG_BASE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [BW-1:0] host_addr,
    input  logic [BW-1:0] host_wdata,
    output logic [BW-1:0] host_rdata,
    output logic          fl_req,
    output logic [BW-1:0] fl_addr,
    output logic [CW-1:0] fl_len,
    input  logic          fl_valid,
    input  logic [7:0]    fl_data,
    output logic          fl_ready,
    output logic          irq
);
    localparam int FW = $clog2(DEPTH + 1);

    logic [FW-1:0] fill;
    logic          buf_full;
    logic          buf_empty;
    logic [7:0]    buf_head;
    logic          start_req;
    logic          start_go;
    logic          active;
    logic          push;
    logic          last_push;
    logic          done_pulse;
    logic          win_pop;
    logic          pop_ok;

    assign pop_ok = win_pop && !buf_empty;
    assign fl_req = start_go;

    irde_regs #(
        .BW(BW), .CW(CW), .FW(FW), .REG_BASE(REG_BASE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .fill(fill), .buf_empty(buf_empty), .buf_head(buf_head),
        .active(active), .start_go(start_go),
        .last_push(last_push), .done_pulse(done_pulse),
        .start_req(start_req), .win_pop(win_pop),
        .flash_addr(fl_addr), .xfer_len(fl_len), .irq(irq)
    );

    irde_fetch #(.CW(CW)) u_fetch (
        .clk(clk), .rst_n(rst_n),
        .start_req(start_req), .count(fl_len),
        .fl_valid(fl_valid), .buf_full(buf_full), .pop_ok(pop_ok),
        .start_go(start_go), .active(active), .fl_ready(fl_ready),
        .push(push), .last_push(last_push), .done_pulse(done_pulse)
    );

    irde_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .wdata(fl_data), .pop(pop_ok),
        .head(buf_head), .fill(fill), .full(buf_full), .empty(buf_empty)
    );

    // R11: completion is only declared once the buffer has been drained
    a_r11_done_drained: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> buf_empty);
endmodule

// File: tb/ind_read_engine_tb.sv
// Bench: behavioural reference (queue and counters) updated each clock
// and compared on every cycle, plus directed register-level checks.
module ind_read_engine_tb;
    localparam int          CLK_PERIOD = 10;
    localparam int          DEPTH      = 8;
    localparam logic [31:0] WBASE      = 32'h0000_1000;
    localparam logic [31:0] WRANGE     = 32'd16;
    localparam logic [31:0] A_CTRL = 32'h00, A_FADDR = 32'h04, A_COUNT = 32'h08,
                            A_TBASE = 32'h0C, A_TRANGE = 32'h10, A_WMARK = 32'h14,
                            A_FILL = 32'h18, A_ISTAT = 32'h1C, A_IEN = 32'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [31:0] host_addr = '0, host_wdata = '0;
    logic [31:0] host_rdata;
    logic        fl_req, fl_ready, irq;
    logic [31:0] fl_addr;
    logic [15:0] fl_len;
    logic        fl_valid = 1'b0;
    logic [7:0]  fl_data = '0;

    ind_read_engine #(.BW(32), .CW(16), .DEPTH(DEPTH), .REG_BASE(32'h0)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .fl_req(fl_req), .fl_addr(fl_addr), .fl_len(fl_len),
        .fl_valid(fl_valid), .fl_data(fl_data), .fl_ready(fl_ready), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference model state
    bit          m_active, m_done, m_above;
    int          m_frem, m_prem;
    logic [7:0]  q[$];
    logic [2:0]  m_stat, m_en;
    logic [31:0] m_faddr, m_wm, m_base, m_range;
    logic [15:0] m_count;
    int          src_idx = 0, src_total = 0;
    bit          src_stall = 0;
    bit          e_win, e_regh, e_rdy, e_push, e_lastp, e_donep, e_popok, e_uf, e_wset, e_start;
    logic [2:0]  e_set, e_clr;

    function automatic logic [7:0] src_byte(input int i);
        return 8'((i * 13 + 5) & 255);
    endfunction

    // Reference model: next state from the inputs present at this edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_done = 0; m_above = 0; m_frem = 0; m_prem = 0;
            q.delete(); m_stat = '0; m_en = '0; m_faddr = '0; m_wm = '0;
            m_base = '0; m_range = '0; m_count = '0;
        end else begin
            e_win   = (host_addr >= m_base) && ((host_addr - m_base) < m_range);
            e_regh  = !e_win && (host_addr[31:6] == 26'd0);
            e_rdy   = m_active && m_frem != 0 && q.size() < DEPTH;
            e_push  = fl_valid && e_rdy;
            e_lastp = e_push && m_frem == 1;
            e_donep = m_active && m_frem == 0 && m_prem == 0;
            e_popok = host_rd && e_win && q.size() > 0;
            e_uf    = host_rd && e_win && q.size() == 0;
            e_wset  = m_wm != 0 && ((q.size() > m_wm && !m_above) || e_lastp);
            m_above = m_wm != 0 && q.size() > m_wm;
            e_set   = {e_uf, e_donep, e_wset};
            e_clr   = (host_wr && e_regh && host_addr[5:2] == 4'd7) ? host_wdata[2:0] : 3'b0;
            e_start = host_wr && e_regh && host_addr[5:2] == 4'd0 && host_wdata[0] && !m_active;
            if (e_popok) begin void'(q.pop_front()); m_prem--; end
            if (e_push)  begin q.push_back(fl_data); m_frem--; src_idx++; end
            if (e_donep) begin m_active = 0; m_done = 1; end
            if (e_start) begin m_active = 1; m_frem = m_count; m_prem = m_count; m_done = 0; end
            m_stat = (m_stat & ~e_clr) | e_set;
            if (host_wr && e_regh) begin
                case (host_addr[5:2])
                    4'd1: m_faddr = host_wdata;
                    4'd2: m_count = host_wdata[15:0];
                    4'd3: m_base  = host_wdata;
                    4'd4: m_range = host_wdata;
                    4'd5: m_wm    = host_wdata;
                    4'd8: m_en    = host_wdata[2:0];
                    default: ;
                endcase
            end
        end
    end

    // Per-cycle comparison of state-only outputs against the model.
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            check("R12", "irq per cycle", {31'd0, irq}, {31'd0, |(m_stat & m_en)});
            check("R4", "fl_ready per cycle", {31'd0, fl_ready},
                  {31'd0, (m_active && m_frem != 0 && q.size() < DEPTH)});
        end
    end

    // Flash byte source: drives the next byte of the running stream.
    always @(negedge clk) begin
        fl_valid <= (src_idx < src_total) && !(src_stall && (cyc % 3 == 0));
        fl_data  <= src_byte(src_idx);
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below 50000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk); host_wr = 0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk); host_rd = 1; host_addr = a; #1 d = host_rdata;
        @(negedge clk); host_rd = 0;
    endtask

    task automatic rd_chk(input string req, input logic [31:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, $sformatf("read @%0h", a), d, exp);
    endtask

    task automatic start_xfer(input bit expect_go);
        logic [15:0] len;
        len = m_count;
        @(negedge clk); host_wr = 1; host_addr = A_CTRL; host_wdata = 32'h1; #1;
        check("R3", "fl_req on start", {31'd0, fl_req}, {31'd0, expect_go});
        if (expect_go) begin
            check("R3", "fl_addr", fl_addr, m_faddr);
            check("R3", "fl_len", {16'd0, fl_len}, {16'd0, len});
            src_total += len;
        end
        @(negedge clk); host_wr = 0;
    endtask

    task automatic wait_fill(input int n);
        while (q.size() < n) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Drain n bytes through the window, walking addresses, ending at the top edge.
    task automatic drain(input int n);
        for (int i = 0; i < n; i++) begin
            logic [31:0] d, exp, a;
            while (q.size() == 0) @(negedge clk);
            a = (i == n - 1) ? (WBASE + WRANGE - 1) : (WBASE + 32'(i % 15));
            @(negedge clk); host_rd = 1; host_addr = a; #1;
            exp = {24'd0, q[0]};
            d = host_rdata;
            check("R5", $sformatf("window pop %0d", i), d, exp);
            @(negedge clk); host_rd = 0;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check("R1", "irq after reset", {31'd0, irq}, 32'd0);
        check("R1", "fl_ready after reset", {31'd0, fl_ready}, 32'd0);
        rd_chk("R1", A_CTRL, 32'd0);
        rd_chk("R1", A_FILL, 32'd0);
        rd_chk("R1", A_ISTAT, 32'd0);
        rd_chk("R1", A_WMARK, 32'd0);

        // R2 programming and read-back
        wr(A_FADDR, 32'h00AB_CD00);  rd_chk("R2", A_FADDR, 32'h00AB_CD00);
        wr(A_COUNT, 32'h0001_000A);  rd_chk("R2", A_COUNT, 32'h0000_000A);
        wr(A_TBASE, WBASE);          rd_chk("R2", A_TBASE, WBASE);
        wr(A_TRANGE, WRANGE);        rd_chk("R2", A_TRANGE, WRANGE);
        wr(A_WMARK, 32'd0);          rd_chk("R2", A_WMARK, 32'd0);
        wr(A_IEN, 32'hF);            rd_chk("R2", A_IEN, 32'h7);

        // 10-byte transfer into an 8-deep buffer, watermark off
        start_xfer(1);
        rd_chk("R3", A_CTRL, 32'h2);
        wait_fill(DEPTH);
        rd_chk("R4", A_FILL, 32'd8);
        check("R4", "fl_ready low when full", {31'd0, fl_ready}, 32'd0);
        start_xfer(0);
        rd_chk("R6", WBASE + WRANGE, 32'd0);
        rd_chk("R6", 32'h0000_0800, 32'd0);
        rd_chk("R6", WBASE - 1, 32'd0);
        rd_chk("R6", A_FILL, 32'd8);
        drain(10);
        rd_chk("R11", A_CTRL, 32'h20);
        rd_chk("R10", A_ISTAT, 32'h2);
        check("R12", "irq with done enabled", {31'd0, irq}, 32'd1);
        wr(A_ISTAT, 32'h2);
        rd_chk("R12", A_ISTAT, 32'h0);
        check("R12", "irq after clear", {31'd0, irq}, 32'd0);

        // Watermark 3 on a 6-byte transfer with a stalling source
        src_stall = 1;
        wr(A_WMARK, 32'd3);
        wr(A_COUNT, 32'd6);
        wr(A_FADDR, 32'h0000_4000);
        start_xfer(1);
        rd_chk("R11", A_CTRL, 32'h2);
        wait_fill(4);
        rd(A_ISTAT, d);
        check("R8", "watermark flag after fill > 3", d & 32'h1, 32'h1);
        wait_fill(6);
        wr(A_ISTAT, 32'h1);
        rd(A_ISTAT, d);
        check("R12", "watermark flag cleared", d & 32'h1, 32'h0);
        drain(6);
        rd_chk("R11", A_ISTAT, 32'h2);
        wr(A_ISTAT, 32'h7);

        // Watermark 5 above a 3-byte transfer: final byte raises it
        wr(A_WMARK, 32'd5);
        wr(A_COUNT, 32'd3);
        wr(A_IEN, 32'h1);
        start_xfer(1);
        wait_fill(3);
        rd_chk("R9", A_ISTAT, 32'h1);
        check("R12", "irq from watermark", {31'd0, irq}, 32'd1);
        wr(A_IEN, 32'h0);
        check("R12", "irq masked", {31'd0, irq}, 32'd0);
        drain(3);
        rd_chk("R11", A_CTRL, 32'h20);
        wr(A_ISTAT, 32'h7);

        // Underflow on an empty window read
        wr(A_IEN, 32'h4);
        rd_chk("R7", WBASE + 4, 32'd0);
        rd_chk("R7", A_ISTAT, 32'h4);
        check("R7", "irq from underflow", {31'd0, irq}, 32'd1);

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule